// File: doc/BRIEF.md
# Paged Address Translation Unit

This block maps a logical address issued by the one running process onto a physical address. A table register holds two values for that process: the memory address of its page table and the number of entries in it. Software reloads the register whenever it switches processes. Pages are 1 KB by default, so the upper bits of the logical address give the page number and the lower ten bits pass through unchanged as the offset.

Each accepted request is first checked against the table length. A page that lies past the end of the table returns a bounds fault at once, and no memory read is made. A page inside the table is looked up in an eight-entry fully associative cache of recent translations. On a hit the answer comes back in the next cycle. On a miss the unit reads the page-table entry over a simple request/acknowledge read port, answers from that entry and copies the entry into the cache. Each entry carries a write-permission bit and an execute-permission bit. An access that either bit forbids returns a protection fault.

Top module: `page_xlate`

## Requirements
- R1: For a fault-free response, `rspPaddr[9:0]` equals bits [9:0] of the accepted logical address. The page number is the logical address shifted right by 10, counting from 0.
- R2: When the page number is greater than or equal to the loaded table length, the cycle after acceptance shows `rspValid` high with `rspFault` = 01, and `memReq` is never raised for that request.
- R3: On a cache miss, `memReq` rises in the cycle after acceptance with `memAddr` = table base + page × 2. It stays high with a stable address until the cycle in which `memAck` is sampled high, and the response follows in the next cycle.
- R4: A fault-free response carries `rspPaddr` = frame × 1024 + offset, where the frame is bits [5:0] of the table entry.
- R5: When the page is in the cache, the response (`rspValid` high) appears in the cycle right after acceptance and no memory read is made.
- R6: Every completed table read is copied into the cache, so a later access to the same page is a hit.
- R7: Cache slots are filled in round-robin order. Once eight pages are cached, the next fill replaces the page that was cached earliest.
- R8: Entry bit 6 permits writes and bit 7 permits execution. Access kind 00 is a read, 01 a write, 10 an execute and 11 a read, and reads are always allowed. A forbidden access returns `rspFault` = 10. Any faulting response carries `rspPaddr` = 0. A fault-free response carries `rspFault` = 00.
- R9: Loading the table register (`ptrLoad` high for one cycle) sets the new base and length and invalidates every cached translation.
- R10: After reset `reqReady` is 1 and both `rspValid` and `memReq` are 0. `reqReady` is low while a table read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptrLoad | input | 1 | Load the table register and invalidate the cache |
| ptrBase | input | 16 | Byte address of the page table |
| ptrLen | input | 7 | Number of table entries |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Unit can accept a request |
| reqAddr | input | 16 | Logical address |
| reqKind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 read |
| rspValid | output | 1 | One-cycle response strobe |
| rspPaddr | output | 16 | Physical address, or 0 on a fault |
| rspFault | output | 2 | 00 none, 01 bounds, 10 protection |
| memReq | output | 1 | Table read request, held until acknowledged |
| memAddr | output | 16 | Table entry byte address |
| memAck | input | 1 | Read data valid |
| memData | input | 8 | Entry: [5:0] frame, [6] write ok, [7] execute ok |

## Verification
The translation is tried with addresses that miss, with addresses that hit, and with pages at, just below and past the table length. Comparing the response timing and the memory read activity for these cases separates the cache path from the table walk path. Entries with different permission bits are driven with all four access kinds, which shows that the read, write and execute rules are each applied separately. A sweep across nine distinct pages and a register reload test the replacement order and the invalidation. In both cases, whether a later access misses or hits shows which cache slot was replaced or cleared.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;

  typedef enum logic [1:0] {
    FAULT_NONE   = 2'b00,
    FAULT_BOUNDS = 2'b01,
    FAULT_PROT   = 2'b10
  } faultCode_t;

  typedef enum logic [1:0] {
    RSP_NONE   = 2'b00,
    RSP_BOUNDS = 2'b01,
    RSP_HIT    = 2'b10,
    RSP_WALK   = 2'b11
  } rspSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;
    logic    fill;
    logic    flush;
    rspSel_t rspSel;
  } xlateStrobe_t;

  // lookup status from datapath to control
  typedef struct packed {
    logic inBounds;
    logic tlbHit;
  } xlateStatus_t;

  // kind: 01 write, 10 execute, others read (always allowed)
  function automatic logic permAllows(input logic [1:0] kind,
                                      input logic wrOk,
                                      input logic exOk);
    case (kind)
      2'b01:   return wrOk;
      2'b10:   return exOk;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/page_xlate_ctrl.sv
module page_xlate_ctrl
  import page_xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic         ptrLoad,
  input  logic         memAck,
  output logic         memReq,
  input  xlateStatus_t status,
  output xlateStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_WALK} state_t;

  state_t state, stateNext;
  logic   walkStale;
  logic   accept;

  assign reqReady = (state == ST_IDLE);
  assign memReq   = (state == ST_WALK);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stateNext      = state;
    strobe         = '0;
    strobe.rspSel  = RSP_NONE;
    strobe.flush   = ptrLoad;
    strobe.capture = accept;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          if (!status.inBounds)    strobe.rspSel = RSP_BOUNDS;
          else if (status.tlbHit)  strobe.rspSel = RSP_HIT;
          else                     stateNext     = ST_WALK;
        end
      end
      ST_WALK: begin
        if (memAck) begin
          strobe.rspSel = RSP_WALK;
          // an entry read under an older table must not be cached
          strobe.fill   = !walkStale && !ptrLoad;
          stateNext     = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      walkStale <= 1'b0;
    end else begin
      state     <= stateNext;
      walkStale <= ptrLoad | (walkStale & ~accept);
    end
  end

endmodule

// File: rtl/page_xlate_dp.sv
module page_xlate_dp
  import page_xlate_pkg::*;
#(
  parameter int LADDR_W     = 16,
  parameter int OFF_W       = 10,
  parameter int FRAME_W     = 6,
  parameter int MEM_AW      = 16,
  parameter int ENTRY_BYTES = 2,
  parameter int TLB_N       = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [MEM_AW-1:0]          ptrBaseIn,
  input  logic [LADDR_W-OFF_W:0]     ptrLenIn,
  input  logic [LADDR_W-1:0]         reqAddr,
  input  logic [1:0]                 reqKind,
  input  logic [FRAME_W+1:0]         memData,
  output logic [MEM_AW-1:0]          memAddr,
  output logic                       rspValid,
  output logic [FRAME_W+OFF_W-1:0]   rspPaddr,
  output logic [1:0]                 rspFault,
  output logic [LADDR_W-OFF_W:0]     curLen,
  input  xlateStrobe_t               strobe,
  output xlateStatus_t               status
);

  localparam int PAGE_W  = LADDR_W - OFF_W;
  localparam int PADDR_W = FRAME_W + OFF_W;
  localparam int IDX_W   = (TLB_N > 1) ? $clog2(TLB_N) : 1;
  localparam int WR_BIT  = FRAME_W;
  localparam int EX_BIT  = FRAME_W + 1;

  // table register
  logic [MEM_AW-1:0]  ptrBase;
  logic [PAGE_W:0]    ptrLen;

  // captured request
  logic [PAGE_W-1:0]  reqPage;
  logic [OFF_W-1:0]   reqOff;
  logic [1:0]         reqKindQ;

  // translation cache
  logic [TLB_N-1:0]   tlbValid;
  logic [PAGE_W-1:0]  tlbPage  [TLB_N];
  logic [FRAME_W-1:0] tlbFrame [TLB_N];
  logic [TLB_N-1:0]   tlbWr;
  logic [TLB_N-1:0]   tlbEx;
  logic [IDX_W-1:0]   rrPtr;

  logic [PAGE_W-1:0]  livePage;
  logic [OFF_W-1:0]   liveOff;
  logic [TLB_N-1:0]   matchVec;
  logic [FRAME_W-1:0] hitFrame;
  logic               hitWr;
  logic               hitEx;
  logic [FRAME_W-1:0] walkFrame;

  assign livePage  = reqAddr[LADDR_W-1:OFF_W];
  assign liveOff   = reqAddr[OFF_W-1:0];
  assign walkFrame = memData[FRAME_W-1:0];
  assign curLen    = ptrLen;

  assign status.inBounds = ({1'b0, livePage} < ptrLen);
  assign status.tlbHit   = |matchVec;

  // one tag comparator per slot
  for (genvar gi = 0; gi < TLB_N; gi++) begin : g_cmp
    assign matchVec[gi] = tlbValid[gi] && (tlbPage[gi] == livePage);
  end

  always_comb begin
    hitFrame = '0;
    hitWr    = 1'b0;
    hitEx    = 1'b0;
    for (int i = 0; i < TLB_N; i++) begin
      if (matchVec[i]) begin
        hitFrame = hitFrame | tlbFrame[i];
        hitWr    = hitWr | tlbWr[i];
        hitEx    = hitEx | tlbEx[i];
      end
    end
  end

  // table register and request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptrBase  <= '0;
      ptrLen   <= '0;
      reqPage  <= '0;
      reqOff   <= '0;
      reqKindQ <= '0;
      memAddr  <= '0;
    end else begin
      if (strobe.flush) begin
        ptrBase <= ptrBaseIn;
        ptrLen  <= ptrLenIn;
      end
      if (strobe.capture) begin
        reqPage  <= livePage;
        reqOff   <= liveOff;
        reqKindQ <= reqKind;
        memAddr  <= ptrBase + MEM_AW'(livePage) * MEM_AW'(ENTRY_BYTES);
      end
    end
  end

  // valid bits and round-robin pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tlbValid <= '0;
      rrPtr    <= '0;
    end else if (strobe.flush) begin
      tlbValid <= '0;
      rrPtr    <= '0;
    end else if (strobe.fill) begin
      tlbValid[rrPtr] <= 1'b1;
      rrPtr <= (rrPtr == IDX_W'(TLB_N - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  // slot contents
  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      tlbPage[rrPtr]  <= reqPage;
      tlbFrame[rrPtr] <= walkFrame;
      tlbWr[rrPtr]    <= memData[WR_BIT];
      tlbEx[rrPtr]    <= memData[EX_BIT];
    end
  end

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspPaddr <= '0;
      rspFault <= FAULT_NONE;
    end else begin
      rspValid <= (strobe.rspSel != RSP_NONE);
      case (strobe.rspSel)
        RSP_BOUNDS: begin
          rspPaddr <= '0;
          rspFault <= FAULT_BOUNDS;
        end
        RSP_HIT: begin
          if (permAllows(reqKind, hitWr, hitEx)) begin
            rspPaddr <= PADDR_W'({hitFrame, liveOff});
            rspFault <= FAULT_NONE;
          end else begin
            rspPaddr <= '0;
            rspFault <= FAULT_PROT;
          end
        end
        RSP_WALK: begin
          if (permAllows(reqKindQ, memData[WR_BIT], memData[EX_BIT])) begin
            rspPaddr <= PADDR_W'({walkFrame, reqOff});
            rspFault <= FAULT_NONE;
          end else begin
            rspPaddr <= '0;
            rspFault <= FAULT_PROT;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int LADDR_W     = 16,
  parameter int OFF_W       = 10,
  parameter int FRAME_W     = 6,
  parameter int MEM_AW      = 16,
  parameter int ENTRY_BYTES = 2,
  parameter int TLB_N       = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ptrLoad,
  input  logic [MEM_AW-1:0]        ptrBase,
  input  logic [LADDR_W-OFF_W:0]   ptrLen,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [LADDR_W-1:0]       reqAddr,
  input  logic [1:0]               reqKind,
  output logic                     rspValid,
  output logic [FRAME_W+OFF_W-1:0] rspPaddr,
  output logic [1:0]               rspFault,
  output logic                     memReq,
  output logic [MEM_AW-1:0]        memAddr,
  input  logic                     memAck,
  input  logic [FRAME_W+1:0]       memData
);

  xlateStrobe_t               strobe;
  xlateStatus_t               status;
  logic [LADDR_W-OFF_W:0]     curLen;

  page_xlate_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .ptrLoad  (ptrLoad),
    .memAck   (memAck),
    .memReq   (memReq),
    .status   (status),
    .strobe   (strobe)
  );

  page_xlate_dp #(
    .LADDR_W     (LADDR_W),
    .OFF_W       (OFF_W),
    .FRAME_W     (FRAME_W),
    .MEM_AW      (MEM_AW),
    .ENTRY_BYTES (ENTRY_BYTES),
    .TLB_N       (TLB_N)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptrBaseIn (ptrBase),
    .ptrLenIn  (ptrLen),
    .reqAddr   (reqAddr),
    .reqKind   (reqKind),
    .memData   (memData),
    .memAddr   (memAddr),
    .rspValid  (rspValid),
    .rspPaddr  (rspPaddr),
    .rspFault  (rspFault),
    .curLen    (curLen),
    .strobe    (strobe),
    .status    (status)
  );

endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int LADDR_W = 16,
  parameter int OFF_W   = 10,
  parameter int FRAME_W = 6,
  parameter int MEM_AW  = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reqValid,
  input logic                     reqReady,
  input logic [LADDR_W-1:0]       reqAddr,
  input logic                     rspValid,
  input logic [FRAME_W+OFF_W-1:0] rspPaddr,
  input logic [1:0]               rspFault,
  input logic                     memReq,
  input logic [MEM_AW-1:0]        memAddr,
  input logic                     memAck,
  input logic [LADDR_W-OFF_W:0]   curLen
);

  logic             accept;
  logic [OFF_W-1:0] lastOff;

  assign accept = reqValid && reqReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lastOff <= '0;
    else if (accept) lastOff <= reqAddr[OFF_W-1:0];
  end

  p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspFault == 2'b00) |-> (rspPaddr[OFF_W-1:0] == lastOff));

  p_bounds_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ({1'b0, reqAddr[LADDR_W-1:OFF_W]} >= curLen))
      |=> (rspValid && rspFault == 2'b01 && !memReq));

  p_read_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  p_walk_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memAck) |=> (rspValid && !memReq));

  p_answer_or_walk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rspValid ^ memReq));

  p_fault_zero_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspFault != 2'b00) |-> (rspPaddr == '0));

  p_fault_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> (rspFault != 2'b11));

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> !reqReady);

endmodule

bind page_xlate page_xlate_chk #(
  .LADDR_W (LADDR_W),
  .OFF_W   (OFF_W),
  .FRAME_W (FRAME_W),
  .MEM_AW  (MEM_AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqAddr  (reqAddr),
  .rspValid (rspValid),
  .rspPaddr (rspPaddr),
  .rspFault (rspFault),
  .memReq   (memReq),
  .memAddr  (memAddr),
  .memAck   (memAck),
  .curLen   (curLen)
);

// File: tb/page_xlate_test.sv
`timescale 1ns/1ps
module page_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptrLoad = 1'b0;
  logic [15:0] ptrBase = '0;
  logic [6:0]  ptrLen = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        rspValid;
  logic [15:0] rspPaddr;
  logic [1:0]  rspFault;
  logic        memReq;
  logic [15:0] memAddr;
  logic        memAck = 1'b0;
  logic [7:0]  memData = '0;

  always #2 clk = ~clk;  // 250 MHz

  page_xlate uut (
    .clk(clk), .rst_n(rst_n), .ptrLoad(ptrLoad), .ptrBase(ptrBase), .ptrLen(ptrLen),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqKind(reqKind),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspFault(rspFault),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [7:0] mem [0:511];
  int         cached[$];
  int         mBase = 0;
  int         mLen  = 0;
  int         walkCount = 0;
  logic       expRsp = 1'b0;
  logic       expMem = 1'b0;
  logic       monOn  = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison of the control outputs against the model
  always @(negedge clk) begin
    #1;
    if (monOn) begin
      chk(rspValid === expRsp, "R5 rspValid per cycle", int'(rspValid), int'(expRsp));
      chk(memReq === expMem, "R3 memReq per cycle", int'(memReq), int'(expMem));
    end
  end

  function automatic bit isCached(input int page);
    foreach (cached[i]) if (cached[i] == page) return 1'b1;
    return 1'b0;
  endfunction

  task automatic setEntry(input int base, input int page, input int frame, input bit wr, input bit ex);
    mem[(base + page * 2) % 512] = {ex, wr, 6'(frame)};
  endtask

  task automatic loadPtr(input int base, input int len);
    @(negedge clk);
    expRsp = 1'b0; expMem = 1'b0;
    ptrLoad = 1'b1; ptrBase = 16'(base); ptrLen = 7'(len);
    @(negedge clk);
    ptrLoad = 1'b0;
    mBase = base; mLen = len;
    cached.delete();  // R9 invalidation
  endtask

  // one translation; req names the requirement under test
  task automatic xlate(input int addr, input int kind, input string req);
    int  page, off, eAddr, frame, expFault, expPaddr, lat;
    bit  miss, wr, ex, ok;
    logic [7:0] ent;
    page = addr / 1024;
    off  = addr % 1024;
    eAddr = (mBase + page * 2) % 65536;
    ent = mem[eAddr % 512];
    frame = int'(ent[5:0]); wr = ent[6]; ex = ent[7];
    ok = (kind == 1) ? wr : (kind == 2) ? ex : 1'b1;
    if (page >= mLen) begin
      miss = 1'b0; expFault = 1; expPaddr = 0;
    end else begin
      miss = !isCached(page);
      expFault = ok ? 0 : 2;
      expPaddr = ok ? frame * 1024 + off : 0;
    end
    @(negedge clk);
    expRsp = 1'b0; expMem = 1'b0;
    chk(reqReady === 1'b1, {req, " R10 ready when idle"}, int'(reqReady), 1);
    reqValid = 1'b1; reqAddr = 16'(addr); reqKind = 2'(kind);
    @(negedge clk);
    reqValid = 1'b0;
    if (miss) begin
      expMem = 1'b1;
      chk(memAddr === 16'(eAddr), {req, " R3 entry address"}, int'(memAddr), eAddr);
      chk(reqReady === 1'b0, {req, " R10 busy during read"}, int'(reqReady), 0);
      lat = walkCount % 3;
      walkCount++;
      for (int w = 0; w < lat; w++) begin
        @(negedge clk);
        chk(memAddr === 16'(eAddr), {req, " R3 address held"}, int'(memAddr), eAddr);
      end
      memAck = 1'b1; memData = ent;
      @(negedge clk);
      memAck = 1'b0;
      expMem = 1'b0;
      cached.push_back(page);            // R6 fill
      if (cached.size() > 8) void'(cached.pop_front());  // R7 oldest leaves
    end
    expRsp = 1'b1;
    chk(rspValid === 1'b1, {req, " response strobe"}, int'(rspValid), 1);
    chk(rspFault === 2'(expFault), {req, " fault code"}, int'(rspFault), expFault);
    chk(rspPaddr === 16'(expPaddr), {req, " physical address"}, int'(rspPaddr), expPaddr);
  endtask

  // expects a hit (no read) or a miss, as the cache order dictates
  task automatic expectLookup(input int addr, input bit wantHit, input string req);
    chk(isCached(addr / 1024) == wantHit, {req, " model cache state"},
        int'(isCached(addr / 1024)), int'(wantHit));
    xlate(addr, 0, req);
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reqReady === 1'b1, "R10 reset ready", int'(reqReady), 1);
    chk(rspValid === 1'b0, "R10 reset rspValid", int'(rspValid), 0);
    chk(memReq === 1'b0, "R10 reset memReq", int'(memReq), 0);
    monOn = 1'b1;

    // first table: pages 0,1,2,3 -> frames 2,3,1,5
    setEntry(16'h100, 0, 2, 1'b1, 1'b0);
    setEntry(16'h100, 1, 3, 1'b1, 1'b1);
    setEntry(16'h100, 2, 1, 1'b0, 1'b0);
    setEntry(16'h100, 3, 5, 1'b0, 1'b1);
    loadPtr(16'h100, 4);

    xlate(1011, 0, "R4 R1 walk 1011");
    xlate(2148, 0, "R4 walk 2148");
    xlate(5012, 0, "R2 page past end");
    xlate(4095, 0, "R2 last page in table walk");
    xlate(4096, 1, "R2 page equal to length");
    xlate(500, 0, "R5 R6 hit page 0");
    xlate(2148, 1, "R8 write to read-only");
    xlate(100, 2, "R8 execute without permission");
    xlate(3079, 2, "R8 execute allowed");
    xlate(3079, 1, "R8 write to execute-only");
    xlate(2200, 3, "R8 kind 11 reads");
    xlate(1500, 1, "R8 write allowed");
    xlate(1030, 2, "R8 execute hit allowed");

    loadPtr(16'h100, 4);
    chk(!isCached(0), "R9 model flushed", int'(isCached(0)), 0);
    xlate(17, 0, "R9 miss after reload");

    // second table: 12 pages -> frame (p+7) mod 64
    for (int p = 0; p < 12; p++) setEntry(16'h040, p, (p + 7) % 64, 1'b1, 1'b1);
    loadPtr(16'h040, 12);
    for (int p = 0; p < 8; p++) expectLookup(p * 1024 + p * 37, 1'b0, "R7 fill slot");
    expectLookup(0 * 1024 + 5, 1'b1, "R7 page 0 still cached");
    expectLookup(8 * 1024 + 9, 1'b0, "R7 ninth page replaces oldest");
    expectLookup(1 * 1024 + 3, 1'b1, "R7 page 1 kept");
    expectLookup(0 * 1024 + 6, 1'b0, "R7 page 0 replaced");
    expectLookup(1 * 1024 + 4, 1'b0, "R7 page 1 replaced next");
    expectLookup(11 * 1024 + 1023, 1'b0, "R2 R1 highest page in bounds");
    xlate(12 * 1024, 0, "R2 first page out of bounds");

    loadPtr(16'h040, 0);
    xlate(0, 0, "R2 R9 zero length table");

    @(negedge clk);
    expRsp = 1'b0; expMem = 1'b0;
    @(negedge clk);
    monOn = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule